// File: doc/BRIEF.md
# Programmable chip-select and wait-state generator

This block sits between a CPU bus master and external memory or peripherals on a 24-bit address space. On each CPU request it decodes the address against four programmable windows. Each window is a base address plus a don't-care mask, and can be switched on or off. The block drives the one active-low select for the winning window and shapes the external read or write strobe. The cycle is stretched to the number of bus states programmed for that window and direction. An address that falls in no window is served by a default window: it has its own timing, but no select line goes low.

Every external cycle is at least two states long. A window can also be put in a mode where an active-low external wait line is watched during the final state. The cycle then holds in that state for as long as the line is low. Settings are loaded through a simple write port, one 24-bit word per write. The word written is the window base, the window mask or the window timing byte.

The CPU side is a valid/ready pair. The master raises `req_valid` with `req_addr` and `req_write`, and must hold all three steady until it sees `req_ready`. `req_ready` is a single-cycle pulse in the last state of the external cycle, and it marks completion. A request is taken only while the block is idle. The first bus state follows the clock edge at which an idle block sees `req_valid`. After each completed cycle there is one idle cycle before the next cycle can begin.

Top module: `csw_gen`

## Requirements
- R1: While reset is held, every `cs_n` bit, `rd_n` and `wr_n` are 1 and `req_ready` is 0.
- R2: Window k matches when `((req_addr ^ base_k) & ~mask_k) == 0` and its enable bit is set (a mask bit of 1 means "ignore this address bit"). When several windows match, the lowest-numbered one wins. Only `cs_n[k]` of the winner goes low, and it stays low for the whole cycle.
- R3: An address that matches no enabled window uses the default window's timing (selector value 4), and all `cs_n` bits stay 1.
- R4: The cycle length in states comes from the 3-bit wait code: 001 gives 2 states, 010 gives 3, 101 gives 4 and 110 gives 5. Reset loads code 010 for both directions of every window.
- R5: Reads use the timing byte bits [2:0] and writes use bits [5:3], so the two directions of one window can differ in length.
- R6: Any other wait code (000, 011, 100, 111) gives a 2-state cycle.
- R7: When timing bit [6] of the selected window is 1 and `ext_wait_n` is 0 during the final state, the cycle holds in that state until `ext_wait_n` is 1. When bit [6] is 0, `ext_wait_n` has no effect.
- R8: `rd_n` (read) or `wr_n` (write) is low from the first state through the final state, and never both at once. `req_ready` is high only in the final state, for one cycle.
- R9: Bit [7] of the timing byte enables a window, and a disabled window never matches. A configuration write that lands while a cycle is running does not change that cycle's select or length; it takes effect from the next request.
- R10: The block accepts a request only while idle. With `req_valid` held high, a 2-state window completes one transfer every 3 cycles.
- R11: A configuration write uses `cfg_sel` to pick the window (0..3, or 4 for the default) and `cfg_kind` to pick the word: 0 = base, 1 = mask, 2 = timing byte in `cfg_wdata[7:0]`. For the default window only kind 2 is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Window selector, 4 = default window |
| cfg_kind | input | 2 | 0 base, 1 mask, 2 timing byte |
| cfg_wdata | input | 24 | Configuration data |
| req_valid | input | 1 | CPU request valid |
| req_ready | output | 1 | Final-state completion pulse |
| req_addr | input | 24 | Request address |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| cs_n | output | 4 | Active-low window selects |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| ext_wait_n | input | 1 | Active-low external wait request |

## Verification
A request driven just after a rising edge is sampled at the next edge. Its first bus state, with the select and the strobe low, is therefore visible half a period after that edge. The bench drives every input 2 ns after a rising edge and reads every output on the falling edge, so each output is compared in the cycle in which it is due. A behavioural model applies each request and configuration write at the same rising edge as the design and is compared at every falling edge. Directed checks count the falling edges that show a strobe, up to and including the one where `req_ready` is seen, and compare that count with the state count the wait code calls for. When the wait line is in use, they also add the cycles for which it was held low.

// File: rtl/csw_pkg.sv
package csw_pkg;

  typedef enum logic [1:0] {
    CFG_BASE = 2'd0,
    CFG_MASK = 2'd1,
    CFG_TIME = 2'd2
  } cfg_kind_e;

  // timing byte: [7] enable, [6] wait-pin mode, [5:3] write code, [2:0] read code
  typedef struct packed {
    logic       en;
    logic       pin;
    logic [2:0] wcode;
    logic [2:0] rcode;
  } timing_t;

  localparam timing_t TIME_RST = '{en: 1'b0, pin: 1'b0, wcode: 3'b010, rcode: 3'b010};

  // index of the final state (states - 1); reserved codes give the 2-state cycle
  function automatic logic [2:0] code_last_state(input logic [2:0] code);
    case (code)
      3'b010:  return 3'd2;
      3'b101:  return 3'd3;
      3'b110:  return 3'd4;
      default: return 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/csw_cfg_regs.sv
module csw_cfg_regs
  import csw_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int NREG   = 4,
  parameter int SEL_W  = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_we,
  input  logic [SEL_W-1:0]               cfg_sel,
  input  logic [1:0]                     cfg_kind,
  input  logic [ADDR_W-1:0]              cfg_wdata,
  output logic [NREG-1:0][ADDR_W-1:0]    base_o,
  output logic [NREG-1:0][ADDR_W-1:0]    mask_o,
  output timing_t [NREG:0]               time_o
);

  // window registers: base, mask and timing
  for (genvar i = 0; i < NREG; i++) begin : g_win
    logic              sel_hit;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] mask_q;
    timing_t           time_q;

    assign sel_hit = cfg_we && (cfg_sel == SEL_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q <= '0;
        mask_q <= '0;
        time_q <= TIME_RST;
      end else if (sel_hit) begin
        case (cfg_kind)
          2'(CFG_BASE): base_q <= cfg_wdata;
          2'(CFG_MASK): mask_q <= cfg_wdata;
          2'(CFG_TIME): time_q <= timing_t'(cfg_wdata[7:0]);
          default:      ;
        endcase
      end
    end

    assign base_o[i] = base_q;
    assign mask_o[i] = mask_q;
    assign time_o[i] = time_q;
  end

  // default window: timing only
  timing_t dflt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dflt_q <= TIME_RST;
    end else if (cfg_we && cfg_sel == SEL_W'(NREG) && cfg_kind == 2'(CFG_TIME)) begin
      dflt_q <= timing_t'(cfg_wdata[7:0]);
    end
  end

  assign time_o[NREG] = dflt_q;

endmodule

// File: rtl/csw_region_match.sv
module csw_region_match #(
  parameter int ADDR_W = 24,
  parameter int NREG   = 4,
  parameter int SEL_W  = 3
) (
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [NREG-1:0][ADDR_W-1:0] base_i,
  input  logic [NREG-1:0][ADDR_W-1:0] mask_i,
  input  logic [NREG-1:0]             en_i,
  output logic [SEL_W-1:0]            idx_o
);

  logic [NREG-1:0] hit;

  for (genvar i = 0; i < NREG; i++) begin : g_cmp
    assign hit[i] = en_i[i] && (((addr_i ^ base_i[i]) & ~mask_i[i]) == '0);
  end

  // lowest-numbered hit wins; none selects the default index NREG
  always_comb begin
    idx_o = SEL_W'(NREG);
    for (int k = NREG - 1; k >= 0; k--) begin
      if (hit[k]) idx_o = SEL_W'(k);
    end
  end

endmodule

// File: rtl/csw_cycle_fsm.sv
module csw_cycle_fsm
  import csw_pkg::*;
#(
  parameter int NREG  = 4,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  timing_t          time_i,
  input  logic [SEL_W-1:0] idx_i,
  input  logic             ext_wait_n,
  output logic             req_ready,
  output logic [NREG-1:0]  cs_n,
  output logic             rd_n,
  output logic             wr_n
);

  logic             busy_q;
  logic             wr_q;
  logic             pin_q;
  logic [2:0]       cnt_q;
  logic [2:0]       last_q;
  logic [SEL_W-1:0] idx_q;
  logic             at_last;
  logic             hold;

  assign at_last   = busy_q && (cnt_q == last_q);
  assign hold      = pin_q && !ext_wait_n;
  assign req_ready = at_last && !hold;

  // state counter; timing is captured when the cycle starts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wr_q   <= 1'b0;
      pin_q  <= 1'b0;
      cnt_q  <= '0;
      last_q <= 3'd1;
      idx_q  <= SEL_W'(NREG);
    end else if (!busy_q) begin
      if (req_valid) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        wr_q   <= req_write;
        pin_q  <= time_i.pin;
        idx_q  <= idx_i;
        last_q <= code_last_state(req_write ? time_i.wcode : time_i.rcode);
      end
    end else if (at_last) begin
      if (!hold) busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 3'd1;
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_cs
    assign cs_n[i] = !(busy_q && idx_q == SEL_W'(i));
  end

  assign rd_n = !(busy_q && !wr_q);
  assign wr_n = !(busy_q && wr_q);

endmodule

// File: rtl/csw_gen.sv
module csw_gen
  import csw_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int NREG   = 4,
  localparam int SEL_W = $clog2(NREG + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [1:0]        cfg_kind,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  output logic [NREG-1:0]   cs_n,
  output logic              rd_n,
  output logic              wr_n,
  input  logic              ext_wait_n
);

  logic [NREG-1:0][ADDR_W-1:0] base_w;
  logic [NREG-1:0][ADDR_W-1:0] mask_w;
  timing_t [NREG:0]            time_w;
  logic [NREG-1:0]             en_w;
  logic [SEL_W-1:0]            idx_w;
  timing_t                     sel_time;

  csw_cfg_regs #(.ADDR_W(ADDR_W), .NREG(NREG), .SEL_W(SEL_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_kind  (cfg_kind),
    .cfg_wdata (cfg_wdata),
    .base_o    (base_w),
    .mask_o    (mask_w),
    .time_o    (time_w)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_en
    assign en_w[i] = time_w[i].en;
  end

  csw_region_match #(.ADDR_W(ADDR_W), .NREG(NREG), .SEL_W(SEL_W)) u_match (
    .addr_i (req_addr),
    .base_i (base_w),
    .mask_i (mask_w),
    .en_i   (en_w),
    .idx_o  (idx_w)
  );

  assign sel_time = time_w[idx_w];

  csw_cycle_fsm #(.NREG(NREG), .SEL_W(SEL_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .time_i     (sel_time),
    .idx_i      (idx_w),
    .ext_wait_n (ext_wait_n),
    .req_ready  (req_ready),
    .cs_n       (cs_n),
    .rd_n       (rd_n),
    .wr_n       (wr_n)
  );

endmodule

// File: rtl/csw_gen_chk.sv
module csw_gen_chk #(
  parameter int NREG = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic [NREG-1:0] cs_n,
  input logic            rd_n,
  input logic            wr_n
);

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n)); // R2

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n)); // R8

  AST_CS_HAS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n != '1) |-> (!rd_n || !wr_n)); // R3

  AST_READY_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!rd_n || !wr_n)); // R8

  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> (rd_n && wr_n && cs_n == '1)); // R10

  AST_FIRST_NOT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rd_n) || $fell(wr_n)) |-> !req_ready); // R4

  AST_RD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && !req_ready) |=> !rd_n); // R8

  AST_WR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && !req_ready) |=> !wr_n); // R8

  AST_CS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((cs_n != '1) && !req_ready) |=> $stable(cs_n)); // R9

endmodule

bind csw_gen csw_gen_chk #(.NREG(NREG)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .cs_n      (cs_n),
  .rd_n      (rd_n),
  .wr_n      (wr_n)
);

// File: tb/csw_gen_test.sv
`timescale 1ns/1ps
module csw_gen_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [1:0]  cfg_kind = '0;
  logic [23:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [3:0]  cs_n;
  logic        rd_n;
  logic        wr_n;
  logic        ext_wait_n = 1'b1;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  csw_gen uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_kind(cfg_kind), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
    .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .ext_wait_n(ext_wait_n)
  );

  // ---------------- behavioural reference ----------------
  logic [23:0] m_base [4];
  logic [23:0] m_mask [4];
  logic [7:0]  m_time [5];
  int m_busy, m_cnt, m_last, m_pin, m_wr, m_idx;

  function automatic int last_of(input logic [2:0] c);
    case (c)
      3'b001:  return 1;
      3'b010:  return 2;
      3'b101:  return 3;
      3'b110:  return 4;
      default: return 1;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) begin
        m_base[k] = '0;
        m_mask[k] = '0;
      end
      for (int k = 0; k < 5; k++) m_time[k] = 8'h12;
      m_busy = 0; m_cnt = 0; m_last = 1; m_pin = 0; m_wr = 0; m_idx = 4;
    end else begin
      if (m_busy != 0) begin
        if (m_cnt == m_last) begin
          if (!(m_pin != 0 && !ext_wait_n)) m_busy = 0;
        end else begin
          m_cnt++;
        end
      end else if (req_valid) begin
        m_idx = 4;
        for (int k = 3; k >= 0; k--)
          if (m_time[k][7] && (((req_addr ^ m_base[k]) & ~m_mask[k]) == 24'd0)) m_idx = k;
        m_busy = 1;
        m_cnt  = 0;
        m_wr   = int'(req_write);
        m_pin  = int'(m_time[m_idx][6]);
        m_last = last_of(req_write ? m_time[m_idx][5:3] : m_time[m_idx][2:0]);
      end
      if (cfg_we) begin
        if (cfg_sel < 3'd4) begin
          if (cfg_kind == 2'd0) m_base[cfg_sel[1:0]] = cfg_wdata;
          if (cfg_kind == 2'd1) m_mask[cfg_sel[1:0]] = cfg_wdata;
          if (cfg_kind == 2'd2) m_time[cfg_sel[1:0]] = cfg_wdata[7:0];
        end else if (cfg_sel == 3'd4 && cfg_kind == 2'd2) begin
          m_time[4] = cfg_wdata[7:0];
        end
      end
    end
  end

  // per-cycle comparison at the falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [3:0] e_cs;
      logic e_rd, e_wr, e_rdy;
      bit bad;
      e_cs = 4'hF;
      if (m_busy != 0 && m_idx < 4) e_cs[m_idx] = 1'b0;
      e_rd  = !(m_busy != 0 && m_wr == 0);
      e_wr  = !(m_busy != 0 && m_wr != 0);
      e_rdy = (m_busy != 0) && (m_cnt == m_last) && !(m_pin != 0 && !ext_wait_n);
      bad = 1'b0;
      vectors++;
      if (cs_n !== e_cs) begin
        bad = 1'b1;
        $display("FAIL R2 cycle compare cs_n got %b exp %b", cs_n, e_cs);
      end
      if (rd_n !== e_rd || wr_n !== e_wr) begin
        bad = 1'b1;
        $display("FAIL R8 cycle compare rd_n/wr_n got %b%b exp %b%b", rd_n, wr_n, e_rd, e_wr);
      end
      if (req_ready !== e_rdy) begin
        bad = 1'b1;
        $display("FAIL R10 cycle compare req_ready got %b exp %b", req_ready, e_rdy);
      end
      if (bad) misses++;
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string tag, input int got, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s got %0d exp %0d", tag, got, exp);
    end
  endtask

  function automatic int cs_index(input logic [3:0] v);
    case (v)
      4'b1111: return -1;
      4'b1110: return 0;
      4'b1101: return 1;
      4'b1011: return 2;
      4'b0111: return 3;
      default: return -2;
    endcase
  endfunction

  task automatic wcfg(input logic [2:0] sel, input logic [1:0] kind, input logic [23:0] d);
    @(posedge clk); #2;
    cfg_we = 1'b1; cfg_sel = sel; cfg_kind = kind; cfg_wdata = d;
    @(posedge clk); #2;
    cfg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  // one access; counts strobe-low states up to and including the ready state
  task automatic access(input logic [23:0] a, input logic w, input bit wait_low,
                        input int rel_at, input int exp_len, input int exp_cs,
                        input string tag);
    int n;
    int first_cs;
    n = 0;
    first_cs = -3;
    @(posedge clk); #2;
    req_valid = 1'b1; req_addr = a; req_write = w;
    ext_wait_n = !wait_low;
    forever begin
      @(negedge clk);
      if (!rd_n || !wr_n) begin
        n++;
        if (n == 1) first_cs = cs_index(cs_n);
      end
      if (req_ready) break;
      if (n > 64) break;
      if (rel_at > 0 && n == rel_at) begin
        @(posedge clk); #2;
        ext_wait_n = 1'b1;
      end
    end
    @(posedge clk); #2;
    req_valid = 1'b0;
    ext_wait_n = 1'b1;
    check(n == exp_len, {tag, " cycle length"}, n, exp_len);
    check(first_cs == exp_cs, {tag, " select index"}, first_cs, exp_cs);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      misses++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs idle while reset is held
    check(cs_n == 4'hF, "R1 cs_n in reset", int'(cs_n), 15);
    check(rd_n && wr_n, "R1 strobes in reset", int'({rd_n, wr_n}), 3);
    check(!req_ready, "R1 ready in reset", int'(req_ready), 0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    idle(2);

    // R3 R4: default window, reset code 010 -> 3 states, no select
    access(24'h123456, 1'b0, 1'b0, 0, 3, -1, "R3");
    access(24'h123456, 1'b1, 1'b0, 0, 3, -1, "R4");

    // window setup (R11): w0 narrow, w1 wide overlapping
    wcfg(3'd0, 2'd0, 24'h200000);
    wcfg(3'd0, 2'd1, 24'h00FFFF);
    wcfg(3'd0, 2'd2, 24'h0000B1);   // en, r=001, w=110
    wcfg(3'd1, 2'd0, 24'h200000);
    wcfg(3'd1, 2'd1, 24'h0FFFFF);
    wcfg(3'd1, 2'd2, 24'h000095);   // en, r=101, w=010
    wcfg(3'd2, 2'd0, 24'h800000);
    wcfg(3'd2, 2'd1, 24'h7FFFFF);
    wcfg(3'd2, 2'd2, 24'h000087);   // en, r=111, w=000
    wcfg(3'd3, 2'd0, 24'h000040);
    wcfg(3'd3, 2'd1, 24'h00003F);
    wcfg(3'd3, 2'd2, 24'h00000E);   // disabled, r=110

    // R2: priority and mask decode
    access(24'h20ABCD, 1'b0, 1'b0, 0, 2, 0, "R2 overlap lowest wins");
    access(24'h25ABCD, 1'b0, 1'b0, 0, 4, 1, "R2 wide window");
    // R5: separate write codes
    access(24'h20ABCD, 1'b1, 1'b0, 0, 5, 0, "R5 write w0");
    access(24'h25ABCD, 1'b1, 1'b0, 0, 3, 1, "R5 write w1");
    // R6: reserved codes
    access(24'h900000, 1'b0, 1'b0, 0, 2, 2, "R6 code 111");
    access(24'hFFFFFF, 1'b1, 1'b0, 0, 2, 2, "R6 code 000");
    // R9: disabled window falls to default
    access(24'h000050, 1'b0, 1'b0, 0, 3, -1, "R9 disabled window");
    wcfg(3'd3, 2'd2, 24'h00008E);
    access(24'h000050, 1'b0, 1'b0, 0, 5, 3, "R9 enabled window");
    // R11: default only stores timing; base write to sel 4 ignored
    wcfg(3'd4, 2'd0, 24'h123456);
    wcfg(3'd4, 2'd2, 24'h000000);
    access(24'h123456, 1'b0, 1'b0, 0, 2, -1, "R11 default timing");

    // R7: wait pin
    wcfg(3'd2, 2'd2, 24'h0000C7);   // en, pin, r=111
    access(24'h900000, 1'b0, 1'b1, 4, 5, 2, "R7 wait held");
    access(24'h900000, 1'b0, 1'b0, 0, 2, 2, "R7 wait idle");
    access(24'h25ABCD, 1'b0, 1'b1, 0, 4, 1, "R7 pin mode off");

    // R9: configuration change in the middle of a cycle
    fork
      access(24'h20ABCD, 1'b1, 1'b0, 0, 5, 0, "R9 mid-cycle write");
      begin
        @(posedge clk);
        wcfg(3'd0, 2'd2, 24'h000089);  // en, r=001, w=001
      end
    join
    access(24'h20ABCD, 1'b1, 1'b0, 0, 2, 0, "R9 next request");

    // R10: back-to-back with valid held
    begin
      int pulses;
      pulses = 0;
      @(posedge clk); #2;
      req_valid = 1'b1; req_addr = 24'h20ABCD; req_write = 1'b0;
      repeat (12) begin
        @(negedge clk);
        if (req_ready) pulses++;
      end
      @(posedge clk); #2;
      req_valid = 1'b0;
      check(pulses == 4, "R10 held-valid throughput", pulses, 4);
      idle(8);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule